// File: doc/BRIEF.md
# Strobe-Written Input FIFO

This block buffers data words that an external processor writes over an asynchronous bus. The processor signals a write by pulling the chip select and the write strobe low together, with the data word on the bus. The FIFO runs entirely on the system clock.

The strobe pair is brought into the clock domain through a short synchroniser. Each completed bus cycle becomes exactly one push, at the moment the synchronised cycle ends. By then the data has long settled. The word stored is the bus data sampled at the last clock edge that saw the cycle active.

On-chip logic drains the FIFO with a one-cycle read enable. The output register shows the next word right after that clock edge, well before the following falling edge.

Full and empty flags follow the word count. A write that lands while the FIFO is full is dropped and raises a sticky overflow flag. The active-low reset is sampled on the clock. It empties the FIFO and clears the overflow flag.

Top module: `strobe_in_fifo`

## Requirements
- R1: While rst_n is low at a rising clock edge, the FIFO is emptied: after that edge empty=1, full=0 and ovf_err=0.
- R2: A bus cycle (bus_ce_n=0 and bus_we_n=0, then released) stores exactly one word, however many clock periods the cycle lasts, and whether it starts just after a rising edge or near a falling edge.
- R3: The stored word is the value of bus_data sampled at the last rising edge where the cycle was active. Data that settles shortly after the strobe falls is therefore captured correctly.
- R4: When rd_en=1 at a rising edge and the FIFO is not empty, rd_data takes the oldest stored word after that edge. Words come out in write order. When no read is accepted, rd_data holds its value.
- R5: The capacity is DEPTH words (255 by default). After DEPTH writes without reads, full=1 and empty=0.
- R6: While the FIFO holds at least one word but fewer than DEPTH words, full=0 and empty=0.
- R7: A write completing while full is discarded, leaving the contents and order unchanged, and sets ovf_err. ovf_err then stays 1 until reset.
- R8: A read requested while empty is ignored: empty stays 1 and rd_data holds its last value.
- R9: After a partial fill and drain moves the pointers off zero (20 writes, 20 reads), a fresh DEPTH-word fill again gives full=1, and the drain returns every word in order across the pointer wrap.
- R10: bus_we_n low with bus_ce_n high, or bus_ce_n low with bus_we_n high, stores nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset, sampled on the rising edge |
| bus_ce_n | input | 1 | Bus chip select, active low, asynchronous |
| bus_we_n | input | 1 | Bus write strobe, active low, asynchronous |
| bus_data | input | DATA_W (13) | Bus write data |
| rd_en | input | 1 | Read request, one cycle per word |
| rd_data | output | DATA_W (13) | Registered read data |
| full | output | 1 | FIFO holds DEPTH words |
| empty | output | 1 | FIFO holds no words |
| ovf_err | output | 1 | Sticky flag: a write arrived while full |

## Verification
The bench builds the block with its defaults: 13-bit words, a depth of 255 and two synchroniser stages. With these values the bench can perform a complete fill to the full flag and then a write beyond it. It can also make the read and write pointers wrap after a 20-word offset, which is the case where an off-by-one in the non-power-of-two wrap would show up. Bus cycles are launched at two different phases relative to the clock, with data settling after the strobe falls. This exercises the synchroniser alignment of data and strobe.

// File: rtl/infifo_pkg.sv
// Package: shared helpers for the strobe-written input FIFO.
// Assumes pointers index a storage array of 'depth' entries, depth >= 2.
package infifo_pkg;

    // Advance a ring pointer, wrapping after depth-1 (depth need not be a power of two).
    function automatic logic [15:0] ring_next(input logic [15:0] ptr, input int depth);
        if (ptr == 16'(depth - 1))
            ring_next = '0;
        else
            ring_next = ptr + 16'd1;
    endfunction

endpackage

// File: rtl/strobe_sync.sv
// strobe_sync: brings the asynchronous bus write cycle into the clock domain.
// The combined cycle (chip select and write strobe both low) passes through
// SYNC_STAGES flops. Bus data passes through an equally deep pipeline, so that
// each data sample lines up with the strobe sample taken at the same edge.
// The hold register keeps the data from the latest edge that saw the cycle
// active. One push pulse is issued when the synchronised cycle ends.
// Assumes the bus holds data stable through the end of the strobe.
module strobe_sync #(
    parameter int DATA_W      = 13,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_ce_n,
    input  logic              bus_we_n,
    input  logic [DATA_W-1:0] bus_data,
    output logic              push,
    output logic [DATA_W-1:0] push_data
);
    localparam int LAST = SYNC_STAGES - 1;

    logic              cyc_raw;
    logic [LAST:0]     cyc_sr;
    logic [DATA_W-1:0] dat_sr [SYNC_STAGES];
    logic              cyc_prev;
    logic [DATA_W-1:0] hold_q;

    assign cyc_raw = ~bus_ce_n & ~bus_we_n;

    genvar g;
    generate
        for (g = 0; g < SYNC_STAGES; g++) begin : g_stage
            if (g == 0) begin : g_first
                // First stage: sample the raw bus cycle and data.
                always_ff @(posedge clk) begin
                    if (!rst_n) begin
                        cyc_sr[0] <= 1'b0;
                        dat_sr[0] <= '0;
                    end else begin
                        cyc_sr[0] <= cyc_raw;
                        dat_sr[0] <= bus_data;
                    end
                end
            end else begin : g_rest
                // Later stages: shift cycle and data in lockstep.
                always_ff @(posedge clk) begin
                    if (!rst_n) begin
                        cyc_sr[g] <= 1'b0;
                        dat_sr[g] <= '0;
                    end else begin
                        cyc_sr[g] <= cyc_sr[g-1];
                        dat_sr[g] <= dat_sr[g-1];
                    end
                end
            end
        end
    endgenerate

    // Remember the last synchronised cycle level for end-of-cycle detection.
    always_ff @(posedge clk) begin
        if (!rst_n) cyc_prev <= 1'b0;
        else        cyc_prev <= cyc_sr[LAST];
    end

    // Hold the data sampled with the most recent active strobe sample.
    always_ff @(posedge clk) begin
        if (!rst_n)              hold_q <= '0;
        else if (cyc_sr[LAST])   hold_q <= dat_sr[LAST];
    end

    assign push      = cyc_prev & ~cyc_sr[LAST];
    assign push_data = hold_q;

    // One bus cycle gives a single-cycle push, never two in a row.
    assert_single_push_R2: assert property (@(posedge clk) disable iff (!rst_n)
        push |=> !push);

    // Data being pushed does not change under the push.
    assert_push_data_stable_R3: assert property (@(posedge clk) disable iff (!rst_n)
        push |-> $stable(push_data));

endmodule

// File: rtl/fifo_ctrl.sv
// fifo_ctrl: pointer, count, flag and overflow tracking for a DEPTH-entry ring.
// A push while full is dropped and latches the sticky error flag.
// A pop while empty is dropped. A push and a pop in the same cycle both proceed,
// as long as each is legal on its own. Assumes DEPTH >= 2.
module fifo_ctrl #(
    parameter int DEPTH = 255
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     push,
    input  logic                     pop_req,
    output logic                     wr_go,
    output logic [$clog2(DEPTH)-1:0] wr_addr,
    output logic                     rd_go,
    output logic [$clog2(DEPTH)-1:0] rd_addr,
    output logic                     full,
    output logic                     empty,
    output logic                     err
);
    import infifo_pkg::*;

    localparam int PTR_W = $clog2(DEPTH);
    localparam int CNT_W = $clog2(DEPTH + 1);

    logic [PTR_W-1:0] wptr, rptr;
    logic [CNT_W-1:0] count;
    logic             is_full, is_empty;

    assign is_full  = (count == CNT_W'(DEPTH));
    assign is_empty = (count == '0);
    assign wr_go    = push & ~is_full;
    assign rd_go    = pop_req & ~is_empty;

    // Write pointer advances on every accepted push.
    always_ff @(posedge clk) begin
        if (!rst_n)     wptr <= '0;
        else if (wr_go) wptr <= PTR_W'(ring_next(16'(wptr), DEPTH));
    end

    // Read pointer advances on every accepted pop.
    always_ff @(posedge clk) begin
        if (!rst_n)     rptr <= '0;
        else if (rd_go) rptr <= PTR_W'(ring_next(16'(rptr), DEPTH));
    end

    // Occupancy count follows accepted pushes and pops.
    always_ff @(posedge clk) begin
        if (!rst_n)              count <= '0;
        else if (wr_go && !rd_go) count <= count + 1'b1;
        else if (rd_go && !wr_go) count <= count - 1'b1;
    end

    // Sticky overflow flag set by a push that found the FIFO full.
    always_ff @(posedge clk) begin
        if (!rst_n)               err <= 1'b0;
        else if (push && is_full) err <= 1'b1;
    end

    assign wr_addr = wptr;
    assign rd_addr = rptr;
    assign full    = is_full;
    assign empty   = is_empty;

    assert_count_bound_R5: assert property (@(posedge clk) disable iff (!rst_n)
        count <= CNT_W'(DEPTH));

    assert_full_drop_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (push && is_full && !pop_req) |=> ($stable(count) && $stable(wptr) && err));

    assert_err_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
        err |=> err);

    assert_empty_pop_ignored_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (pop_req && is_empty && !push) |=> ($stable(rptr) && count == '0));

endmodule

// File: rtl/fifo_store.sv
// fifo_store: word storage with a registered read port.
// Accepted writes land at wr_addr. An accepted read loads the output register
// from rd_addr, and otherwise the output holds its value. Contents are not reset.
module fifo_store #(
    parameter int DATA_W = 13,
    parameter int DEPTH  = 255
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     wr_go,
    input  logic [$clog2(DEPTH)-1:0] wr_addr,
    input  logic [DATA_W-1:0]        wr_data,
    input  logic                     rd_go,
    input  logic [$clog2(DEPTH)-1:0] rd_addr,
    output logic [DATA_W-1:0]        rd_data
);
    logic [DATA_W-1:0] mem [DEPTH];
    logic [DATA_W-1:0] out_q;

    // Store an accepted word.
    always_ff @(posedge clk) begin
        if (wr_go) mem[wr_addr] <= wr_data;
    end

    // Load the output register on an accepted read, otherwise hold.
    always_ff @(posedge clk) begin
        if (!rst_n)     out_q <= '0;
        else if (rd_go) out_q <= mem[rd_addr];
    end

    assign rd_data = out_q;

    assert_dout_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_go |=> $stable(out_q));

endmodule

// File: rtl/strobe_in_fifo.sv
// strobe_in_fifo: top of the strobe-written input FIFO.
// Asynchronous bus writes are synchronised into pushes. The clock-domain logic
// drains words with rd_en. Reset is synchronous and active low.
module strobe_in_fifo #(
    parameter int DATA_W      = 13,
    parameter int DEPTH       = 255,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_ce_n,
    input  logic              bus_we_n,
    input  logic [DATA_W-1:0] bus_data,
    input  logic              rd_en,
    output logic [DATA_W-1:0] rd_data,
    output logic              full,
    output logic              empty,
    output logic              ovf_err
);
    localparam int PTR_W = $clog2(DEPTH);

    logic              push;
    logic [DATA_W-1:0] push_data;
    logic              wr_go, rd_go;
    logic [PTR_W-1:0]  wr_addr, rd_addr;

    strobe_sync #(.DATA_W(DATA_W), .SYNC_STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .bus_ce_n(bus_ce_n), .bus_we_n(bus_we_n),
        .bus_data(bus_data), .push(push), .push_data(push_data)
    );

    fifo_ctrl #(.DEPTH(DEPTH)) u_ctrl (
        .clk(clk), .rst_n(rst_n), .push(push), .pop_req(rd_en),
        .wr_go(wr_go), .wr_addr(wr_addr), .rd_go(rd_go), .rd_addr(rd_addr),
        .full(full), .empty(empty), .err(ovf_err)
    );

    fifo_store #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_store (
        .clk(clk), .rst_n(rst_n), .wr_go(wr_go), .wr_addr(wr_addr),
        .wr_data(push_data), .rd_go(rd_go), .rd_addr(rd_addr), .rd_data(rd_data)
    );

    assert_full_not_empty_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !(full && empty));

    assert_reset_state_R1: assert property (@(posedge clk)
        !rst_n |=> (empty && !full && !ovf_err));

endmodule

// File: tb/strobe_in_fifo_tb.sv
`timescale 1ns/1ps
module strobe_in_fifo_tb;
    localparam int DW = 13;
    localparam int DEPTH = 255;

    logic clk = 1'b0, rst_n = 1'b0, bus_ce_n = 1'b1, bus_we_n = 1'b1, rd_en = 1'b0;
    logic [DW-1:0] bus_data = '0;
    logic [DW-1:0] rd_data;
    logic full, empty, ovf_err;
    int total = 0, bad = 0;
    logic [DW-1:0] last_rd;

    always #2 clk = ~clk;

    strobe_in_fifo u_dut (
        .clk(clk), .rst_n(rst_n), .bus_ce_n(bus_ce_n), .bus_we_n(bus_we_n),
        .bus_data(bus_data), .rd_en(rd_en), .rd_data(rd_data),
        .full(full), .empty(empty), .ovf_err(ovf_err)
    );

    // Vector fields: {op[1:0] (1=write, 2=read), exp_empty, exp_full, data[12:0]}
    localparam int NV = 9;
    localparam logic [16:0] VEC [NV] = '{
        {2'd1, 1'b0, 1'b0, 13'h1FFF},
        {2'd1, 1'b0, 1'b0, 13'h0001},
        {2'd1, 1'b0, 1'b0, 13'h1ABC},
        {2'd2, 1'b0, 1'b0, 13'h1FFF},
        {2'd2, 1'b0, 1'b0, 13'h0001},
        {2'd1, 1'b0, 1'b0, 13'h0555},
        {2'd2, 1'b0, 1'b0, 13'h1ABC},
        {2'd2, 1'b1, 1'b0, 13'h0555},
        {2'd2, 1'b1, 1'b0, 13'h0555}
    };

    task automatic chk(input string req, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Bus write cycle starting 'phase' ns after a rising edge; data settles 1 ns after the strobe.
    task automatic bus_write(input logic [DW-1:0] d, input real phase, input int low_cycles);
        @(posedge clk); #(phase);
        bus_ce_n = 1'b0; bus_we_n = 1'b0;
        #1 bus_data = d;
        repeat (low_cycles) @(posedge clk);
        #(phase);
        bus_ce_n = 1'b1; bus_we_n = 1'b1;
        #0.5 bus_data = 13'h0AAA;
        repeat (5) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic rd_one();
        @(negedge clk); rd_en = 1'b1;
        @(negedge clk); rd_en = 1'b0;
    endtask

    task automatic do_reset();
        @(negedge clk); rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic finish_run();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    endtask

    initial begin
        #(4 * 150000);
        total++; bad++;
        $display("FAIL watchdog: actual=timeout expected=done");
        finish_run();
    end

    initial begin
        do_reset();
        chk("R1 empty", empty, 1); chk("R1 full", full, 0); chk("R1 ovf", ovf_err, 0);

        // Table walk: R2 R3 R4 R6 R8
        for (int v = 0; v < NV; v++) begin
            if (VEC[v][16:15] == 2'd1) bus_write(VEC[v][12:0], 1.0, 3);
            else begin
                rd_one();
                chk("R4 table rd_data", rd_data, VEC[v][12:0]);
            end
            chk("R6 table empty", empty, VEC[v][14]);
            chk("R6 table full", full, VEC[v][13]);
        end

        // R8: read while empty keeps data and empty
        last_rd = rd_data;
        rd_one(); rd_one();
        chk("R8 hold", rd_data, last_rd); chk("R8 empty", empty, 1);

        // R10: half-asserted cycles store nothing
        @(negedge clk); bus_we_n = 1'b0; bus_data = 13'h0123;
        repeat (6) @(negedge clk); bus_we_n = 1'b1;
        repeat (6) @(negedge clk);
        chk("R10 we only", empty, 1);
        bus_ce_n = 1'b0; repeat (6) @(negedge clk); bus_ce_n = 1'b1;
        repeat (6) @(negedge clk);
        chk("R10 ce only", empty, 1);

        // R2: a long cycle gives one word
        bus_write(13'h0777, 3.0, 12);
        chk("R2 long not empty", empty, 0);
        rd_one();
        chk("R2 long data", rd_data, 13'h0777);
        chk("R2 single word", empty, 1);

        // R5 R7: fill, overflow, drain
        for (int i = 0; i < DEPTH; i++) bus_write(DW'(i == 0 ? 13'h1FFF : i), 1.0, 3);
        chk("R5 full", full, 1); chk("R5 not empty", empty, 0); chk("R7 ovf before", ovf_err, 0);
        bus_write(13'h0ABC, 3.0, 3);
        chk("R7 ovf set", ovf_err, 1); chk("R7 still full", full, 1);
        for (int i = 0; i < DEPTH; i++) begin
            rd_one();
            chk("R7 drain order", rd_data, (i == 0) ? 13'h1FFF : i);
        end
        chk("R7 empty after drain", empty, 1);
        chk("R7 sticky", ovf_err, 1);
        do_reset();
        chk("R1 ovf cleared", ovf_err, 0); chk("R1 empty again", empty, 1);

        // R9: offset pointers, then full fill across wrap
        for (int i = 70; i < 90; i++) bus_write(DW'(i), 1.0, 3);
        chk("R6 partial full", full, 0); chk("R6 partial empty", empty, 0);
        for (int i = 70; i < 90; i++) begin
            rd_one();
            chk("R9 offset data", rd_data, i);
        end
        chk("R9 offset empty", empty, 1);
        for (int i = 0; i < DEPTH; i++) bus_write(DW'(i + 300), 3.0, 3);
        chk("R9 full after wrap", full, 1);
        for (int i = 0; i < DEPTH; i++) begin
            rd_one();
            chk("R9 wrap order", rd_data, i + 300);
        end
        chk("R9 empty", empty, 1); chk("R9 no ovf", ovf_err, 0);

        finish_run();
    end
endmodule